// File: doc/BRIEF.md
# ULPI PHY-Side Bus Arbiter

This block sits on the transceiver side of an 8-bit, single-data-rate, low-pin-count link/PHY interface that runs on one rising-edge clock. It owns the bus direction signal, so it decides in every cycle which side drives the shared data byte. While the Link owns the bus, the block watches for a command byte. It then accepts the command with a flow-control strobe and routes it. A transmit command opens a stream of payload bytes toward the transmitter. A register command reads or writes a small configuration array. That array takes the place of the static transceiver mode pins: speed select, termination select, operating mode and the two line pull-down enables.

The bidirectional data pins are split into an input byte, an output byte and an output enable, which the pad ring joins. A not-ready input stands for an internal start-up condition. While it is high in idle, the block keeps the bus and ignores the Link. Transmit payload leaves on a simple valid/data stream, framed by start and end pulses.

Top module: `ulpiPhyArbiter`

## Requirements
- R1: While reset is low, `dir` is 1, `nxt` is 0 and `dataOe` is 0. The configuration array resets to 0x01 at address 0, 0x03 at address 1 and 0x00 elsewhere. After reset is released with `notReady` low, `dir` is 0 two clock edges later and the block is idle.
- R2: In idle, a byte whose bits [7:6] are 00, including the idle value 0x00, is ignored. STP in idle is also ignored. Neither raises `nxt` or `dir`, nor produces transmit output.
- R3: A byte with bits [7:6]=01 is a transmit command, with the packet ID in bits [3:0]. If it is on the bus in idle cycle n, `nxt` is 1 from cycle n+1 until STP is seen. `txStart` pulses with `txPid` in cycle n+2. Each payload byte on the bus in cycle m≥n+2 comes out on `txData` with `txValid` in cycle m+1. STP in the cycle after the last byte gives a `txEnd` pulse one cycle later.
- R4: `nxt` and `dir` are never high in the same cycle. A byte on the bus is taken as accepted only in a cycle where `nxt` is 1.
- R5: A byte with bits [7:6]=10 is a register write to address [5:0]. With the command in idle cycle n, `nxt` is 1 in n+1 and n+2. The data byte is taken from cycle n+2. If STP is high in cycle n+3, the register holds the new value from cycle n+4.
- R6: A register write whose data byte is not followed by STP in the next cycle leaves the array unchanged.
- R7: A byte with bits [7:6]=11 is a register read of address [5:0]. With the command in idle cycle n, `nxt` is 1 in n+1. `dir` is 1 in n+2 (turnaround) and in n+3, when `dataOut` carries the register value. `dir` falls in n+4 (turnaround), and idle resumes in n+5.
- R8: `dataOe` is 1 only in a cycle where `dir` was already 1 in the previous cycle. `dataOut` is 0x00 whenever `dataOe` is 0.
- R9: If `notReady` is high in an idle cycle, `dir` is 1 from the next cycle on and Link bytes are ignored. Once `notReady` is seen low, one turnaround cycle with `dir` at 0 follows, then idle.
- R10: Addresses 4 and above are unimplemented. Writes to them complete normally but have no effect, and reads return 0x00.
- R11: Register 0 drives `xcvrSel` from bits [1:0], `termSel` from bit 2 and `opMode` from bits [4:3]. Register 1 drives `dpPullDown` from bit 0 and `dmPullDown` from bit 1. All registers store and read back all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| notReady | input | 1 | PHY cannot accept Link data while high |
| dataIn | input | 8 | Byte driven by the Link |
| dataOut | output | 8 | Byte driven by the PHY |
| dataOe | output | 1 | PHY drives the data pins |
| dir | output | 1 | Bus direction, 1 = PHY owns the bus |
| nxt | output | 1 | Current Link byte accepted |
| stp | input | 1 | Link ends the current stream |
| txStart | output | 1 | Pulse: transmit command accepted |
| txPid | output | 4 | Packet ID of the last transmit command |
| txValid | output | 1 | Transmit payload byte valid |
| txData | output | 8 | Transmit payload byte |
| txEnd | output | 1 | Pulse: transmit stream ended by STP |
| xcvrSel | output | 2 | Speed select field |
| termSel | output | 1 | Termination select field |
| opMode | output | 2 | Operating mode field |
| dpPullDown | output | 1 | D+ pull-down enable |
| dmPullDown | output | 1 | D- pull-down enable |

## Verification
The properties assume the Link plays by the handshake. It raises STP only in the cycle after its last byte, and it changes `notReady` only while the block is idle, in hold, or in a read turnaround. The stimulus drives Link bytes at the falling clock edge and holds each command byte until it has seen `nxt`. It releases the bus (data 0x00) during read turnarounds and pulses STP for exactly one cycle. The configuration-stability property relies on STP never being asserted at a register-write point unless a commit is intended, and every directed sequence keeps to that.

// File: rtl/ulpiPhyPkg.sv
package ulpiPhyPkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int NUM_REGS = 4;

  localparam int ADDR_MODE = 0;
  localparam int ADDR_PULL = 1;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_TURN_DN,
    ST_IDLE,
    ST_TX_CMD,
    ST_TX_DATA,
    ST_WR_CMD,
    ST_WR_DATA,
    ST_WR_STP,
    ST_RD_CMD,
    ST_RD_TURN,
    ST_RD_DATA
  } phyState_t;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_TX    = 2'b01,
    CMD_REGWR = 2'b10,
    CMD_REGRD = 2'b11
  } cmdKind_t;

  typedef struct packed {
    logic capAddr;
    logic capWrData;
    logic commitWr;
    logic loadRd;
    logic driveRd;
    logic txStart;
    logic txByte;
    logic txEnd;
  } phyStrobes_t;

  function automatic logic [7:0] cfgResetVal(input int idx);
    case (idx)
      ADDR_MODE: return 8'h01;
      ADDR_PULL: return 8'h03;
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ulpiPhyRegArray.sv
module ulpiPhyRegArray
  import ulpiPhyPkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int ADDR_W_P = ADDR_W,
  parameter int NUM_REGS_P = NUM_REGS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W_P-1:0] wrAddr,
  input  logic [DATA_W_P-1:0] wrData,
  input  logic [ADDR_W_P-1:0] rdAddr,
  output logic [DATA_W_P-1:0] rdData,
  output logic [1:0]          xcvrSel,
  output logic                termSel,
  output logic [1:0]          opMode,
  output logic                dpPullDown,
  output logic                dmPullDown
);

  localparam int FLAT_W = NUM_REGS_P * DATA_W_P;

  logic [FLAT_W-1:0] regFlat;

  for (genvar g = 0; g < NUM_REGS_P; g++) begin : gReg
    localparam logic [7:0] RST_VAL = cfgResetVal(g);
    logic [DATA_W_P-1:0] q;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= DATA_W_P'(RST_VAL);
      end else if (wrEn && (wrAddr == ADDR_W_P'(g))) begin
        q <= wrData;
      end
    end

    assign regFlat[g*DATA_W_P +: DATA_W_P] = q;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS_P; i++) begin
      if (rdAddr == ADDR_W_P'(i)) begin
        rdData = regFlat[i*DATA_W_P +: DATA_W_P];
      end
    end
  end

  assign xcvrSel    = regFlat[ADDR_MODE*DATA_W_P + 0 +: 2];
  assign termSel    = regFlat[ADDR_MODE*DATA_W_P + 2];
  assign opMode     = regFlat[ADDR_MODE*DATA_W_P + 3 +: 2];
  assign dpPullDown = regFlat[ADDR_PULL*DATA_W_P + 0];
  assign dmPullDown = regFlat[ADDR_PULL*DATA_W_P + 1];

endmodule

// File: rtl/ulpiPhyCtrl.sv
module ulpiPhyCtrl
  import ulpiPhyPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        notReady,
  input  logic [1:0]  cmdBits,
  input  logic        stp,
  output logic        dir,
  output logic        nxt,
  output logic        dataOe,
  output phyStrobes_t strb
);

  phyState_t state, stateNext;
  cmdKind_t  cmdKind;

  assign cmdKind = cmdKind_t'(cmdBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HOLD;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_HOLD: begin
        if (!notReady) stateNext = ST_TURN_DN;
      end
      ST_TURN_DN: stateNext = ST_IDLE;
      ST_IDLE: begin
        if (notReady) begin
          stateNext = ST_HOLD;
        end else begin
          unique case (cmdKind)
            CMD_TX:    stateNext = ST_TX_CMD;
            CMD_REGWR: begin
              stateNext    = ST_WR_CMD;
              strb.capAddr = 1'b1;
            end
            CMD_REGRD: begin
              stateNext    = ST_RD_CMD;
              strb.capAddr = 1'b1;
            end
            default:   stateNext = ST_IDLE;
          endcase
        end
      end
      ST_TX_CMD: begin
        strb.txStart = 1'b1;
        stateNext    = ST_TX_DATA;
      end
      ST_TX_DATA: begin
        if (stp) begin
          strb.txEnd = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          strb.txByte = 1'b1;
        end
      end
      ST_WR_CMD:  stateNext = ST_WR_DATA;
      ST_WR_DATA: begin
        strb.capWrData = 1'b1;
        stateNext      = ST_WR_STP;
      end
      ST_WR_STP: begin
        strb.commitWr = stp;
        stateNext     = ST_IDLE;
      end
      ST_RD_CMD: begin
        strb.loadRd = 1'b1;
        stateNext   = ST_RD_TURN;
      end
      ST_RD_TURN: stateNext = ST_RD_DATA;
      ST_RD_DATA: begin
        strb.driveRd = 1'b1;
        stateNext    = ST_TURN_DN;
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  assign dir = (state == ST_HOLD) || (state == ST_RD_TURN) || (state == ST_RD_DATA);

  assign nxt = (state == ST_TX_CMD) || (state == ST_TX_DATA) || (state == ST_WR_CMD) ||
               (state == ST_WR_DATA) || (state == ST_RD_CMD);

  assign dataOe = (state == ST_RD_DATA);

endmodule

// File: rtl/ulpiPhyDatapath.sv
module ulpiPhyDatapath
  import ulpiPhyPkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int ADDR_W_P = ADDR_W,
  parameter int NUM_REGS_P = NUM_REGS,
  parameter int PID_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  phyStrobes_t         strb,
  input  logic [DATA_W_P-1:0] dataIn,
  output logic [DATA_W_P-1:0] dataOut,
  output logic                txStart,
  output logic [PID_W-1:0]    txPid,
  output logic                txValid,
  output logic [DATA_W_P-1:0] txData,
  output logic                txEnd,
  output logic [1:0]          xcvrSel,
  output logic                termSel,
  output logic [1:0]          opMode,
  output logic                dpPullDown,
  output logic                dmPullDown
);

  logic [ADDR_W_P-1:0] addrQ;
  logic [DATA_W_P-1:0] wrDataQ;
  logic [DATA_W_P-1:0] rdHoldQ;
  logic [DATA_W_P-1:0] rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      rdHoldQ <= '0;
    end else begin
      if (strb.capAddr)   addrQ   <= dataIn[ADDR_W_P-1:0];
      if (strb.capWrData) wrDataQ <= dataIn;
      if (strb.loadRd)    rdHoldQ <= rdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txStart <= 1'b0;
      txPid   <= '0;
      txValid <= 1'b0;
      txData  <= '0;
      txEnd   <= 1'b0;
    end else begin
      txStart <= strb.txStart;
      txValid <= strb.txByte;
      txEnd   <= strb.txEnd;
      if (strb.txStart) txPid  <= dataIn[PID_W-1:0];
      if (strb.txByte)  txData <= dataIn;
    end
  end

  assign dataOut = strb.driveRd ? rdHoldQ : '0;

  ulpiPhyRegArray #(
    .DATA_W_P  (DATA_W_P),
    .ADDR_W_P  (ADDR_W_P),
    .NUM_REGS_P(NUM_REGS_P)
  ) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (strb.commitWr),
    .wrAddr    (addrQ),
    .wrData    (wrDataQ),
    .rdAddr    (addrQ),
    .rdData    (rdData),
    .xcvrSel   (xcvrSel),
    .termSel   (termSel),
    .opMode    (opMode),
    .dpPullDown(dpPullDown),
    .dmPullDown(dmPullDown)
  );

endmodule

// File: rtl/ulpiPhyArbiter.sv
module ulpiPhyArbiter
  import ulpiPhyPkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int ADDR_W_P = ADDR_W,
  parameter int NUM_REGS_P = NUM_REGS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                notReady,
  input  logic [DATA_W_P-1:0] dataIn,
  output logic [DATA_W_P-1:0] dataOut,
  output logic                dataOe,
  output logic                dir,
  output logic                nxt,
  input  logic                stp,
  output logic                txStart,
  output logic [3:0]          txPid,
  output logic                txValid,
  output logic [DATA_W_P-1:0] txData,
  output logic                txEnd,
  output logic [1:0]          xcvrSel,
  output logic                termSel,
  output logic [1:0]          opMode,
  output logic                dpPullDown,
  output logic                dmPullDown
);

  phyStrobes_t strb;

  ulpiPhyCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .notReady(notReady),
    .cmdBits (dataIn[DATA_W_P-1 -: 2]),
    .stp     (stp),
    .dir     (dir),
    .nxt     (nxt),
    .dataOe  (dataOe),
    .strb    (strb)
  );

  ulpiPhyDatapath #(
    .DATA_W_P  (DATA_W_P),
    .ADDR_W_P  (ADDR_W_P),
    .NUM_REGS_P(NUM_REGS_P),
    .PID_W     (4)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .txStart   (txStart),
    .txPid     (txPid),
    .txValid   (txValid),
    .txData    (txData),
    .txEnd     (txEnd),
    .xcvrSel   (xcvrSel),
    .termSel   (termSel),
    .opMode    (opMode),
    .dpPullDown(dpPullDown),
    .dmPullDown(dmPullDown)
  );

endmodule

// File: rtl/ulpiPhyChecker.sv
module ulpiPhyChecker (
  input logic       clk,
  input logic       rstN,
  input logic       notReady,
  input logic       stp,
  input logic       dir,
  input logic       nxt,
  input logic       dataOe,
  input logic [7:0] dataOut,
  input logic       txStart,
  input logic       txValid,
  input logic       txEnd,
  input logic [6:0] cfgBus
);

  // R4: the PHY never throttles Link data while it owns the bus
  p_nxt_not_with_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    dir |-> !nxt);

  // R3: payload leaves only after a cycle where the byte was accepted
  p_tx_after_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(nxt));

  // R3: start, payload and end never coincide
  p_tx_framing_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txStart, txValid, txEnd}));

  // R8: the PHY drives only after a turnaround cycle
  p_oe_after_turn_r8: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dir && $past(dir) && !$past(dataOe)));

  // R8: the bus rise cycle is always a turnaround
  p_rise_is_turn_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dir) |-> !dataOe);

  // R8: idle output byte is zero
  p_quiet_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));

  // R9: while not ready, an owned and undriven bus stays owned
  p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (notReady && $past(notReady) && $past(dir) && !$past(dataOe)) |-> dir);

  // R6: configuration changes only right after an STP cycle
  p_cfg_needs_stp_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stp) |-> $stable(cfgBus));

endmodule

bind ulpiPhyArbiter ulpiPhyChecker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .notReady(notReady),
  .stp     (stp),
  .dir     (dir),
  .nxt     (nxt),
  .dataOe  (dataOe),
  .dataOut (dataOut),
  .txStart (txStart),
  .txValid (txValid),
  .txEnd   (txEnd),
  .cfgBus  ({xcvrSel, termSel, opMode, dpPullDown, dmPullDown})
);

// File: tb/ulpiPhyArbiter_test.sv
module ulpiPhyArbiter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       notReady = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       stp = 1'b0;
  logic [7:0] dataOut;
  logic       dataOe, dir, nxt;
  logic       txStart, txValid, txEnd;
  logic [3:0] txPid;
  logic [7:0] txData;
  logic [1:0] xcvrSel, opMode;
  logic       termSel, dpPullDown, dmPullDown;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ulpiPhyArbiter uut (
    .clk(clk), .rstN(rstN), .notReady(notReady), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .dir(dir), .nxt(nxt), .stp(stp),
    .txStart(txStart), .txPid(txPid), .txValid(txValid), .txData(txData),
    .txEnd(txEnd), .xcvrSel(xcvrSel), .termSel(termSel), .opMode(opMode),
    .dpPullDown(dpPullDown), .dmPullDown(dmPullDown)
  );

  // op[23:22] 0=write 1=read, addr[21:16], data[15:8], expected read[7:0]
  localparam logic [23:0] VEC [12] = '{
    24'h40_00_01, 24'h41_00_03, 24'h42_00_00, 24'h02_A5_00,
    24'h42_00_A5, 24'h00_1A_00, 24'h40_00_1A, 24'h3F_FF_00,
    24'h7F_00_00, 24'h01_00_00, 24'h41_00_00, 24'h45_00_00
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic doWrite(input logic [5:0] addr, input logic [7:0] data, input logic withStp,
                         input string req);
    dataIn = {2'b10, addr};
    step();
    chk({req, " wr cmd nxt"}, {dir, nxt}, 2'b01);
    step();
    chk({req, " wr data nxt"}, nxt, 1'b1);
    dataIn = data;
    step();
    chk({req, " wr stp slot nxt"}, nxt, 1'b0);
    dataIn = 8'h00;
    stp = withStp;
    step();
    stp = 1'b0;
  endtask

  task automatic doRead(input logic [5:0] addr, input logic [7:0] exp, input string req);
    dataIn = {2'b11, addr};
    step();
    chk({req, " rd cmd dir/nxt"}, {dir, nxt}, 2'b01);
    dataIn = 8'h00;
    step();
    chk({req, " rd turn dir/oe/nxt"}, {dir, dataOe, nxt}, 3'b100);
    step();
    chk({req, " rd data dir/oe"}, {dir, dataOe}, 2'b11);
    chk({req, " rd data value"}, dataOut, exp);
    step();
    chk({req, " rd turn-down dir/oe/nxt"}, {dir, dataOe, nxt}, 3'b000);
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    chk("R1 reset dir/nxt/oe", {dir, nxt, dataOe}, 3'b100);
    chk("R1 reset cfg", {xcvrSel, termSel, opMode, dpPullDown, dmPullDown}, 7'b01_0_00_11);
    rstN = 1'b1;
    step();
    chk("R1 release turnaround dir", dir, 1'b0);
    step();
    chk("R1 idle nxt", nxt, 1'b0);

    // R2: reserved command and stray STP in idle
    dataIn = 8'h2A;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 reserved byte ignored", {dir, nxt, txStart, txValid}, 4'b0000);
    end
    dataIn = 8'h00;
    stp = 1'b1;
    step();
    stp = 1'b0;
    step();
    chk("R2 idle stp ignored", {dir, nxt, txEnd}, 3'b000);

    // R7 / R10 / R5: table of register accesses
    for (int i = 0; i < 12; i++) begin
      logic [23:0] v;
      v = VEC[i];
      if (v[23:22] == 2'b00) begin
        doWrite(v[21:16], v[15:8], 1'b1, (v[21:16] >= 6'd4) ? "R10" : "R5");
      end else begin
        doRead(v[21:16], v[7:0], (v[21:16] >= 6'd4) ? "R10" : "R7");
      end
    end

    // R11: field mapping after reg0=0x1A, reg1=0x00
    chk("R11 mode fields", {xcvrSel, termSel, opMode}, 5'b10_0_11);
    chk("R11 pull fields", {dpPullDown, dmPullDown}, 2'b00);

    // R6: write without STP is dropped
    doWrite(6'd2, 8'h77, 1'b0, "R6");
    doRead(6'd2, 8'hA5, "R6");

    // R5: committed write visible right after
    doWrite(6'd0, 8'h05, 1'b1, "R5");
    chk("R5 fields after commit", {xcvrSel, termSel, opMode}, 5'b01_1_00);

    // R3: transmit PID 5, payload 11 22 33
    dataIn = 8'h45;
    step();
    chk("R3 tx cmd nxt", {dir, nxt}, 2'b01);
    step();
    chk("R3 tx start", {txStart, txPid}, 5'b1_0101);
    dataIn = 8'h11;
    step();
    chk("R3 byte0", {txValid, txData}, 9'h1_11);
    chk("R4 nxt during payload", {dir, nxt}, 2'b01);
    dataIn = 8'h22;
    step();
    chk("R3 byte1", {txValid, txData}, 9'h1_22);
    dataIn = 8'h33;
    step();
    chk("R3 byte2", {txValid, txData}, 9'h1_33);
    dataIn = 8'h00;
    stp = 1'b1;
    step();
    stp = 1'b0;
    chk("R3 end", {txEnd, txValid, nxt}, 3'b100);
    step();
    chk("R3 end is a pulse", txEnd, 1'b0);

    // R9: not ready holds the bus and ignores commands
    notReady = 1'b1;
    step();
    chk("R9 hold dir/oe/nxt", {dir, dataOe, nxt}, 3'b100);
    dataIn = 8'h80;
    step();
    chk("R9 cmd ignored", {dir, nxt}, 2'b10);
    step();
    chk("R9 still held", {dir, nxt}, 2'b10);
    notReady = 1'b0;
    dataIn = 8'h00;
    step();
    chk("R9 release turnaround", {dir, nxt}, 2'b00);
    step();
    doRead(6'd0, 8'h05, "R9");

    report();
  end

endmodule